// File: doc/BRIEF.md
# Single-Wire Bit-Symbol Transmit Encoder

This block sends requests onto a single-wire bus that is driven by an ordinary asynchronous serial transmitter. Each logical bit is carried by one complete 8N1 serial character. A one becomes the character 0x7F and a zero becomes 0x7D, so every logical byte takes eight serial frames on the line. The serializer is inside the block. Its bit period is set in clock cycles by a divisor input. When that input is zero, the block uses a divisor derived at elaboration from the clock frequency and the 230400 baud line rate.

The client presents a request with a valid/ready handshake. The request carries a kind code, and for commands a payload length. The block always sends the flag byte for the requested kind first. For a command, the payload bytes come from a separate byte stream with its own valid/ready handshake. The leading byte of that stream is an address byte that this bus does not use, so it is taken from the stream and thrown away. The remaining bytes are then expanded bit by bit. A completed request ends with a one-cycle done pulse. If the stream has no byte ready when the block needs one, the block stops at that byte boundary and pulses an error instead.

Top module: `swi_sym_tx`

## Requirements
- R1: While reset is held and after it is released, `txd` is high, `req_ready` is high, and `pay_ready`, `done` and `err` are low until a request arrives. Asserting reset in the middle of a transfer returns the block to this state at once.
- R2: Each serial character has one low start bit, eight data bits least significant first and one high stop bit, each held for the effective divisor in clock cycles. Logical one is sent as character 0x7F and logical zero as 0x7D; no other character value ever appears.
- R3: Every logical byte is sent as exactly eight characters, its bit 0 first and bit 7 last.
- R4: A command request (`req_kind` = 0) sends the command flag (default 0x77), then `req_len` payload bytes in stream order.
- R5: For a command, the first byte accepted from the stream is consumed but not sent, so exactly `req_len`+1 stream bytes are accepted.
- R6: Kinds 1 (transmit request, default flag 0x88), 2 (idle, 0xBB) and 3 (sleep, 0xCC) send only their flag byte. They accept no stream byte and ignore `req_len`.
- R7: A new character never starts before the stop bit of the previous one has completed.
- R8: `req_ready` is low from acceptance until completion, and requests offered meanwhile are ignored. After the final stop bit, `done` is high for exactly one cycle and `req_ready` is high again.
- R9: If `pay_valid` is low in a cycle where the block needs a stream byte, the block sends nothing more and pulses `err` for one cycle without `done`. The bytes already sent are always whole bytes.
- R10: A `baud_div` of 0 selects the built-in divisor round(CLK_HZ/230400), which is 217 clocks per bit at the default 50 MHz clock.
- R11: A command with `req_len` = 0 still consumes the address byte and then sends only the command flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per serial bit; 0 selects built-in divisor |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | 0 command, 1 transmit request, 2 idle, 3 sleep |
| req_len | input | LEN_W | Payload bytes to send for a command |
| req_ready | output | 1 | Block idle, request accepted when valid |
| pay_valid | input | 1 | Stream byte available |
| pay_data | input | 8 | Stream byte |
| pay_ready | output | 1 | Block takes the stream byte this cycle |
| txd | output | 1 | Serial line, idles high |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when the stream stalls |

## Verification
The assertions assume that `baud_div` is either 0 or at least 2, and that it stays constant while a request is in flight. They also assume that the stream either holds a byte ready when one is asked for or has stopped supplying bytes for the rest of the request. The bench changes the divisor only between requests, while the block is idle. It drives `pay_valid` from a count of available bytes that is fixed for each request, so a stall is always a clean end of data rather than a glitch. Requests and stream bytes are driven on the falling clock edge, so the handshakes are sampled cleanly.

// File: rtl/swi_tx_pkg.sv
package swi_tx_pkg;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_TXREQ = 2'd1,
    KIND_IDLE  = 2'd2,
    KIND_SLEEP = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_SEND,
    ST_WAIT,
    ST_FETCH
  } ctrl_state_e;

  // Rounded clocks-per-bit for a given clock and line rate.
  function automatic int unsigned calc_div(input int unsigned clk_hz,
                                           input int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

endpackage

// File: rtl/swi_uart_ser.sv
module swi_uart_ser #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  input  logic [7:0]       char_in,
  output logic             txd,
  output logic             busy,
  output logic             done
);

  localparam int FRAME_BITS = 10;
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic                  active_q, active_d;
  logic [FRAME_BITS-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [DIV_W-1:0]      cnt_q, cnt_d;
  logic                  done_q, done_d;
  logic                  ser_en;

  assign ser_en = active_q | load;

  always_comb begin
    active_d = active_q;
    shreg_d  = shreg_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (load) begin
        active_d = 1'b1;
        shreg_d  = {1'b1, char_in, 1'b0};
        idx_d    = '0;
        cnt_d    = '0;
      end
    end else if (cnt_q == div - DIV_ONE) begin
      cnt_d   = '0;
      shreg_d = {1'b1, shreg_q[FRAME_BITS-1:1]};
      if (idx_q == LAST_IDX) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q + DIV_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      shreg_q  <= '1;
      idx_q    <= '0;
      cnt_q    <= '0;
    end else if (ser_en) begin
      active_q <= active_d;
      shreg_q  <= shreg_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign txd  = active_q ? shreg_q[0] : 1'b1;
  assign busy = active_q;
  assign done = done_q;

endmodule

// File: rtl/swi_bit_expand.sv
module swi_bit_expand #(
  parameter int         BYTE_W   = 8,
  parameter logic [7:0] SYM_ONE  = 8'h7F,
  parameter logic [7:0] SYM_ZERO = 8'h7D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              step,
  output logic [7:0]        sym,
  output logic              last
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] bits_q, bits_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              exp_en;

  assign exp_en = load | step;

  always_comb begin
    bits_d = bits_q;
    cnt_d  = cnt_q;
    if (load) begin
      bits_d = byte_in;
      cnt_d  = '0;
    end else if (step) begin
      bits_d = {1'b0, bits_q[BYTE_W-1:1]};
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (exp_en) begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sym  = bits_q[0] ? SYM_ONE : SYM_ZERO;
  assign last = (cnt_q == LAST_BIT);

endmodule

// File: rtl/swi_tx_ctrl.sv
module swi_tx_ctrl
  import swi_tx_pkg::*;
#(
  parameter int         LEN_W      = 8,
  parameter logic [7:0] FLAG_CMD   = 8'h77,
  parameter logic [7:0] FLAG_TXREQ = 8'h88,
  parameter logic [7:0] FLAG_IDLE  = 8'hBB,
  parameter logic [7:0] FLAG_SLEEP = 8'hCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic             pay_valid,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  output logic             exp_load,
  output logic [7:0]       exp_byte,
  output logic             exp_step,
  input  logic             exp_last,
  output logic             ser_load,
  input  logic             ser_done,
  output logic             done,
  output logic             err
);

  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  ctrl_state_e      state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic             remain_en;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [7:0]       flag_code;

  always_comb begin
    unique case (req_kind_e'(req_kind))
      KIND_CMD:   flag_code = FLAG_CMD;
      KIND_TXREQ: flag_code = FLAG_TXREQ;
      KIND_IDLE:  flag_code = FLAG_IDLE;
      default:    flag_code = FLAG_SLEEP;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    remain_en = 1'b0;
    done_d    = 1'b0;
    err_d     = 1'b0;
    exp_load  = 1'b0;
    exp_byte  = flag_code;
    exp_step  = 1'b0;
    ser_load  = 1'b0;
    pay_ready = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          exp_load  = 1'b1;
          remain_en = 1'b1;
          if (req_kind_e'(req_kind) == KIND_CMD) begin
            remain_d = req_len;
            state_d  = ST_SKIP;
          end else begin
            remain_d = '0;
            state_d  = ST_SEND;
          end
        end
      end
      ST_SKIP: begin
        pay_ready = 1'b1;
        if (pay_valid) begin
          state_d = ST_SEND;
        end else begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SEND: begin
        ser_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (ser_done) begin
          if (!exp_last) begin
            exp_step = 1'b1;
            state_d  = ST_SEND;
          end else if (remain_q != '0) begin
            state_d = ST_FETCH;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_FETCH: begin
        pay_ready = 1'b1;
        if (pay_valid) begin
          exp_load  = 1'b1;
          exp_byte  = pay_data;
          remain_en = 1'b1;
          remain_d  = remain_q - LEN_ONE;
          state_d   = ST_SEND;
        end else begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         remain_q <= '0;
    else if (remain_en) remain_q <= remain_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/swi_sym_tx.sv
module swi_sym_tx
  import swi_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned LINE_BAUD  = 230_400,
  parameter int          DIV_W      = 12,
  parameter int          LEN_W      = 8,
  parameter logic [7:0]  SYM_ONE    = 8'h7F,
  parameter logic [7:0]  SYM_ZERO   = 8'h7D,
  parameter logic [7:0]  FLAG_CMD   = 8'h77,
  parameter logic [7:0]  FLAG_TXREQ = 8'h88,
  parameter logic [7:0]  FLAG_IDLE  = 8'hBB,
  parameter logic [7:0]  FLAG_SLEEP = 8'hCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [LEN_W-1:0] req_len,
  output logic             req_ready,
  input  logic             pay_valid,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  output logic             txd,
  output logic             done,
  output logic             err
);

  localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(calc_div(CLK_HZ, LINE_BAUD));

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] eff_div;
  logic             exp_load, exp_step, exp_last;
  logic [7:0]       exp_byte, exp_sym;
  logic             ser_load, ser_busy, ser_done;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign eff_div = (baud_div == '0) ? DEF_DIV : baud_div;

  swi_tx_ctrl #(
    .LEN_W      (LEN_W),
    .FLAG_CMD   (FLAG_CMD),
    .FLAG_TXREQ (FLAG_TXREQ),
    .FLAG_IDLE  (FLAG_IDLE),
    .FLAG_SLEEP (FLAG_SLEEP)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_len   (req_len),
    .req_ready (req_ready),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_ready (pay_ready),
    .exp_load  (exp_load),
    .exp_byte  (exp_byte),
    .exp_step  (exp_step),
    .exp_last  (exp_last),
    .ser_load  (ser_load),
    .ser_done  (ser_done),
    .done      (done),
    .err       (err)
  );

  swi_bit_expand #(
    .BYTE_W   (8),
    .SYM_ONE  (SYM_ONE),
    .SYM_ZERO (SYM_ZERO)
  ) i_expand (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (exp_load),
    .byte_in (exp_byte),
    .step    (exp_step),
    .sym     (exp_sym),
    .last    (exp_last)
  );

  swi_uart_ser #(
    .DIV_W (DIV_W)
  ) i_ser (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .div     (eff_div),
    .load    (ser_load),
    .char_in (exp_sym),
    .txd     (txd),
    .busy    (ser_busy),
    .done    (ser_done)
  );

endmodule

// File: rtl/swi_sym_tx_chk.sv
module swi_sym_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic req_ready,
  input logic done,
  input logic err,
  input logic pay_ready,
  input logic ser_load,
  input logic ser_busy
);

  // R2: line rests high whenever the block is ready for a request
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> txd);

  // R7: a character is launched only onto an idle serializer
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |-> !ser_busy);

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: completion coincides with readiness for the next request
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R9: an abort never reports completion and leaves the block ready
  assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && req_ready));

  // R9: stream bytes are taken only between characters, never mid-byte
  assert_fetch_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (!ser_busy && txd));

endmodule

bind swi_sym_tx swi_sym_tx_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txd       (txd),
  .req_ready (req_ready),
  .done      (done),
  .err       (err),
  .pay_ready (pay_ready),
  .ser_load  (ser_load),
  .ser_busy  (ser_busy)
);

// File: tb/test_swi_sym_tx.sv
module test_swi_sym_tx;

  localparam int CLK_PERIOD = 10;
  localparam int DEF_DIV    = (50_000_000 + 115_200) / 230_400;
  localparam int WATCHDOG   = 190_000;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  len;
    logic [11:0] div;
    logic [3:0]  avail;
    logic [31:0] pay;
  } vec_t;

  // kind, len, divisor, stream bytes available, payload (first byte in [7:0])
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'd3, 12'd4, 4'd4, 32'h00FF01A5},
    '{2'd0, 8'd0, 12'd5, 4'd1, 32'h00000000},
    '{2'd1, 8'd0, 12'd4, 4'd0, 32'h00000000},
    '{2'd2, 8'd0, 12'd0, 4'd4, 32'h11223344},
    '{2'd3, 8'd2, 12'd3, 4'd4, 32'h55667788},
    '{2'd0, 8'd4, 12'd7, 4'd5, 32'h3C7F8000},
    '{2'd0, 8'd3, 12'd4, 4'd2, 32'h0055AA33},
    '{2'd0, 8'd2, 12'd4, 4'd0, 32'h00001234}
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] baud_div;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [7:0]  req_len;
  logic        req_ready;
  logic        pay_valid;
  logic [7:0]  pay_data;
  logic        pay_ready;
  logic        txd;
  logic        done;
  logic        err;

  int checks;
  int errors;
  int cycles;
  logic [7:0] chars [64];
  int nchar;
  int frame_err;
  int done_cnt;
  int err_cnt;
  int cur_div;
  logic [7:0] stream [8];
  int sidx;
  int savail;
  logic xfer_pend;

  swi_sym_tx i_swi_sym_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_div  (baud_div),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_len   (req_len),
    .req_ready (req_ready),
    .pay_valid (pay_valid),
    .pay_data  (pay_data),
    .pay_ready (pay_ready),
    .txd       (txd),
    .done      (done),
    .err       (err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flag_of(input logic [1:0] k);
    case (k)
      2'd0:    return 8'h77;
      2'd1:    return 8'h88;
      2'd2:    return 8'hBB;
      default: return 8'hCC;
    endcase
  endfunction

  function automatic logic [7:0] decoded(input int j);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = (chars[8*j+b] == 8'h7F);
    return v;
  endfunction

  // watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= WATCHDOG) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
        summary();
        $finish;
      end
    end
  end

  // stream source: fixed number of available bytes per request
  initial begin
    xfer_pend = 1'b0;
    pay_valid = 1'b0;
    pay_data  = 8'h00;
    forever begin
      @(negedge clk);
      if (xfer_pend) sidx++;
      pay_valid = (sidx < savail);
      pay_data  = stream[sidx % 8];
      xfer_pend = pay_ready && pay_valid;
    end
  end

  // pulse counters
  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (err)  err_cnt++;
    end
  end

  // line monitor: serial character decoder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        int d;
        logic [7:0] ch;
        d = cur_div;
        repeat (d / 2) @(negedge clk);
        if (txd !== 1'b0) frame_err++;
        for (int b = 0; b < 8; b++) begin
          repeat (d) @(negedge clk);
          ch[b] = txd;
        end
        repeat (d) @(negedge clk);
        if (txd !== 1'b1) frame_err++;
        if (nchar < 64) chars[nchar] = ch;
        nchar++;
      end
    end
  end

  task automatic setup(input vec_t v);
    cur_div   = (v.div == 0) ? DEF_DIV : int'(v.div);
    baud_div  = v.div;
    stream[0] = 8'hE3;
    for (int b = 0; b < 4; b++) stream[b+1] = v.pay[8*b +: 8];
    for (int b = 5; b < 8; b++) stream[b] = 8'h00;
    savail    = int'(v.avail);
    sidx      = 0;
    nchar     = 0;
    frame_err = 0;
    done_cnt  = 0;
    err_cnt   = 0;
  endtask

  task automatic wait_end();
    int t;
    t = 0;
    while (done_cnt + err_cnt == 0 && t < 40_000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    bit is_cmd;
    int need, consumed, nbytes;
    bit exp_err, sym_ok;
    logic [7:0] exp_byte;
    setup(v);
    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_kind  = v.kind;
    req_len   = v.len;
    @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    is_cmd   = (v.kind == 2'd0);
    need     = is_cmd ? int'(v.len) + 1 : 0;
    exp_err  = (savail < need);
    consumed = exp_err ? savail : need;
    nbytes   = exp_err ? savail : (is_cmd ? int'(v.len) + 1 : 1);
    chk(done_cnt == (exp_err ? 0 : 1), "R8 done pulse count", done_cnt, exp_err ? 0 : 1);
    chk(err_cnt == (exp_err ? 1 : 0), "R9 err pulse count", err_cnt, exp_err ? 1 : 0);
    chk(nchar == 8 * nbytes, "R3 characters per request", nchar, 8 * nbytes);
    sym_ok = (frame_err == 0);
    for (int c = 0; c < nchar && c < 64; c++)
      if (chars[c] != 8'h7F && chars[c] != 8'h7D) sym_ok = 1'b0;
    chk(sym_ok, "R2 framing and symbol codes", frame_err, 0);
    chk(sidx == consumed, is_cmd ? "R5 stream bytes consumed" : "R6 stream untouched",
        sidx, consumed);
    for (int j = 0; j < nbytes && j < 8; j++) begin
      exp_byte = (j == 0) ? flag_of(v.kind) : v.pay[8*(j-1) +: 8];
      if (j == 0 && !is_cmd)
        chk(decoded(j) == exp_byte, "R6 flag only", int'(decoded(j)), int'(exp_byte));
      else if (j == 0)
        chk(decoded(j) == exp_byte, "R4 command flag first", int'(decoded(j)), int'(exp_byte));
      else
        chk(decoded(j) == exp_byte, "R5 payload after skipped byte", int'(decoded(j)),
            int'(exp_byte));
    end
    chk(req_ready === 1'b1 && txd === 1'b1, "R8 ready and idle after end",
        int'({req_ready, txd}), 3);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_kind  = 2'd0;
    req_len   = 8'd0;
    baud_div  = 12'd4;
    cur_div   = 4;
    savail    = 0;
    sidx      = 0;
    nchar     = 0;
    frame_err = 0;
    done_cnt  = 0;
    err_cnt   = 0;
    for (int b = 0; b < 8; b++) stream[b] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    chk(req_ready === 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(pay_ready === 1'b0 && done === 1'b0 && err === 1'b0, "R1 outputs low in reset",
        int'({pay_ready, done, err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(txd === 1'b1 && req_ready === 1'b1, "R1 idle after release", int'({txd, req_ready}), 3);

    // table: R2 R3 R4 R5 R6 R9 R10 (vector 3, default divisor) R11 (vector 1)
    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R8: requests offered while busy are ignored
    setup('{2'd1, 8'd0, 12'd4, 4'd0, 32'h0});
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'd1;
    @(negedge clk);
    req_kind  = 2'd2;
    repeat (5) @(negedge clk);
    chk(req_ready === 1'b0, "R8 not ready while busy", int'(req_ready), 0);
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_end();
    repeat (100) @(negedge clk);
    chk(nchar == 8, "R8 busy request ignored", nchar, 8);
    chk(decoded(0) == 8'h88, "R8 only first packet sent", int'(decoded(0)), 8'h88);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);

    // R1: reset in the middle of a command
    setup('{2'd0, 8'd3, 12'd4, 4'd4, 32'h00FF01A5});
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'd0;
    req_len   = 8'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && req_ready === 1'b1 && pay_ready === 1'b0, "R1 mid-run reset",
        int'({txd, req_ready, pay_ready}), 6);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(txd === 1'b1 && req_ready === 1'b1 && done_cnt == 0, "R1 quiet after reset",
        int'({txd, req_ready}), 3);

    summary();
    $finish;
  end

endmodule